// File: doc/BRIEF.md
# Handshaked Byte Transfer Engine

This block is the device end of a byte-wide packet link between a host and a peripheral controller. Bytes move through one 8-bit shift register. Three active-low handshake lines pace the transfer. The host drives two of them: in-progress (`tip_n`) and acknowledge (`ack_n`). The device drives the third, request (`req_n`). A direction bit picks the way data flows.

- **Host to device.** Each byte step copies the shift register into a 16-entry capture buffer. When the host releases in-progress, the buffer is handed on as a packet.
- **Device to host.** Each byte step puts the next byte of a preloaded response into the shift register. Request then tells the host when the response has been used up.

Byte steps are triggered by a change of level on the handshake lines, not by a clock edge. Each cycle the block compares both host lines with their values from the previous cycle and takes at most one byte step.

- **Shift-register flag.** Every step, every end of transfer, every idle acknowledge toggle and every response load sets this flag. A host read clears it.
- **Idle sync.** While in-progress stays inactive, request follows the acknowledge line.
- **Data waiting.** A pending response pulls request low.

Packet decoding and response generation are not part of the block. In their place are a packet-ready pulse with a length and a read port into the capture buffer, plus a write-and-load port for the response buffer.

Top module: `hsl_byte_link`

## Requirements
- R1: After reset, `req_n` is 1, `sr_flag` is 0, `pkt_ready` is 0, `pkt_len` is 0 and `sr_q` is 0.
- R2: With `dir_h2d`=1 and `tip_n`=0, each cycle in which `tip_n` or `ack_n` differs from its value in the previous cycle does two things:
  - it stores `sr_q` into the next capture slot, starting at slot 0;
  - it sets `sr_flag` at the next clock edge.
- R3: The capture buffer holds 16 bytes. Any further capture step in the same transfer is dropped: the 16 stored bytes stay unchanged and `sr_flag` is not set.
- R4: When `tip_n` is 1 in a cycle and was 0 in the previous cycle, the transfer ends:
  - `sr_flag` is set;
  - if at least one byte was captured, `pkt_ready` pulses high for exactly one cycle and `pkt_len` shows the byte count;
  - the capture count returns to 0.
- R5: With `dir_h2d`=0 and `tip_n`=0, each line change while response bytes remain moves the next response byte into `sr_q` and sets `sr_flag`. The step that delivers the last byte drives `req_n` to 1. Further changes leave `sr_q` unchanged.
- R6: When `tip_n` is 1 in both the current and the previous cycle and `ack_n` changes, `req_n` takes the new value of `ack_n` and `sr_flag` is set.
- R7: When `tip_n` is 1, `ack_n` is not toggling and response bytes remain, `req_n` is driven to 0.
- R8: Pulsing `rsp_load` with a length of 1 to 128 does two things:
  - it restarts delivery at response byte 0, even when an earlier response is only partly read;
  - it sets `sr_flag`.
- R9: `sr_rd` clears `sr_flag`. A flag-setting event in the same cycle wins and leaves the flag at 1.
- R10: While `tip_n` and `ack_n` hold their previous values, no byte step happens: no capture, no `sr_q` change from the response, no flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tip_n | input | 1 | Transfer in progress from host, active low |
| ack_n | input | 1 | Acknowledge from host, active low |
| dir_h2d | input | 1 | 1: host sends to device, 0: device sends to host |
| sr_wr | input | 1 | Host write strobe for the shift register |
| sr_wdata | input | 8 | Host write data for the shift register |
| sr_rd | input | 1 | Host read of the shift register; clears the flag |
| sr_q | output | 8 | Shift register contents |
| sr_flag | output | 1 | Shift-register interrupt flag |
| req_n | output | 1 | Request to host, active low |
| pkt_ready | output | 1 | One-cycle pulse: captured packet complete |
| pkt_len | output | 5 | Byte count of the last completed packet |
| cap_rd_addr | input | 4 | Capture buffer read address |
| cap_rd_data | output | 8 | Capture buffer read data (combinational) |
| rsp_wr | input | 1 | Response buffer byte write strobe |
| rsp_wr_addr | input | 7 | Response buffer write address |
| rsp_wr_data | input | 8 | Response buffer write data |
| rsp_load | input | 1 | Start a new response of `rsp_len` bytes |
| rsp_len | input | 8 | Response length, 1 to 128 |

## Verification
The assertions assume the host changes `tip_n` and `ack_n` only between clock edges. They also assume that a response is loaded only while no device-to-host step is under way, and that `sr_wr` does not collide with a response step. Under those conditions every flag set, request change and packet pulse can be traced to a single cycle of line change.

The stimulus keeps within these limits in three ways:
- it drives all inputs on the falling clock edge;
- it writes the shift register and clears the flag in a cycle whose lines are steady, then changes the lines in the next cycle;
- it loads responses only while `tip_n` is high and `ack_n` is steady.

// File: rtl/hsl_pkg.sv
// Shared types for the handshaked byte link.
// Assumes: nothing; pure type definitions.
package hsl_pkg;

    // Kind of event decided for the current cycle.
    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_CAPTURE = 3'd1,
        ST_RESPOND = 3'd2,
        ST_SYNC    = 3'd3,
        ST_END     = 3'd4,
        ST_IDLE    = 3'd5
    } step_e;

endpackage

// File: rtl/hsl_line_watch.sv
// Remembers last cycle's handshake line levels and flags changes.
// Assumes: lines are already synchronous to clk; reset value is idle (high).
module hsl_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic tip_n,
    input  logic ack_n,
    output logic prev_tip_n,
    output logic prev_ack_n,
    output logic lines_changed,
    output logic ack_changed
);

    // Hold previous-cycle levels of both host lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tip_n <= 1'b1;
            prev_ack_n <= 1'b1;
        end else begin
            prev_tip_n <= tip_n;
            prev_ack_n <= ack_n;
        end
    end

    // Compare current against previous levels.
    always_comb begin
        ack_changed   = (ack_n != prev_ack_n);
        lines_changed = ack_changed || (tip_n != prev_tip_n);
    end

endmodule

// File: rtl/hsl_capture_buf.sv
// Host-to-device capture buffer: appends bytes until full, cleared per packet.
// Assumes: push while full is discarded; clear has priority over push.
module hsl_capture_buf #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          clear,
    output logic [CW-1:0] count,
    output logic          full,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [DEPTH];

    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rd_addr];

    // Advance or clear the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push && !full) begin
            count <= count + CW'(1);
        end
    end

    // Store the pushed byte into the next free slot.
    always_ff @(posedge clk) begin
        if (push && !full && !clear) begin
            mem[count[AW-1:0]] <= din;
        end
    end

endmodule

// File: rtl/hsl_response_buf.sv
// Device-to-host response buffer: written by the response source, read in order.
// Assumes: load and pop never coincide; load lengths above DEPTH are clamped.
module hsl_response_buf #(
    parameter  int DEPTH = 128,
    parameter  int W     = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          load,
    input  logic [LW-1:0] load_len,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          avail,
    output logic          last
);

    logic [W-1:0]  mem [DEPTH];
    logic [LW-1:0] rd_idx;
    logic [LW-1:0] len;

    assign avail = (rd_idx < len);
    assign last  = avail && ((rd_idx + LW'(1)) == len);
    assign head  = mem[rd_idx[AW-1:0]];

    // Byte storage written by the response source.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Response length and read position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx <= '0;
            len    <= '0;
        end else if (load) begin
            rd_idx <= '0;
            len    <= (load_len > LW'(DEPTH)) ? LW'(DEPTH) : load_len;
        end else if (pop && avail) begin
            rd_idx <= rd_idx + LW'(1);
        end
    end

endmodule

// File: rtl/hsl_byte_link.sv
// Device side of a handshaked byte link: captures host bytes, presents
// response bytes, mirrors acknowledge in idle, raises a shift-register flag.
// Assumes: host lines synchronous to clk; at most one byte step per cycle.
module hsl_byte_link #(
    parameter  int DATA_W    = 8,
    parameter  int CAP_DEPTH = 16,
    parameter  int RSP_DEPTH = 128,
    localparam int CNT_W     = $clog2(CAP_DEPTH + 1),
    localparam int CAW       = $clog2(CAP_DEPTH),
    localparam int RAW       = $clog2(RSP_DEPTH),
    localparam int LEN_W     = $clog2(RSP_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tip_n,
    input  logic              ack_n,
    input  logic              dir_h2d,
    input  logic              sr_wr,
    input  logic [DATA_W-1:0] sr_wdata,
    input  logic              sr_rd,
    output logic [DATA_W-1:0] sr_q,
    output logic              sr_flag,
    output logic              req_n,
    output logic              pkt_ready,
    output logic [CNT_W-1:0]  pkt_len,
    input  logic [CAW-1:0]    cap_rd_addr,
    output logic [DATA_W-1:0] cap_rd_data,
    input  logic              rsp_wr,
    input  logic [RAW-1:0]    rsp_wr_addr,
    input  logic [DATA_W-1:0] rsp_wr_data,
    input  logic              rsp_load,
    input  logic [LEN_W-1:0]  rsp_len
);
    import hsl_pkg::*;

    logic              prev_tip_n, prev_ack_n, lines_changed, ack_changed;
    logic [CNT_W-1:0]  cap_count;
    logic              cap_full;
    logic [DATA_W-1:0] rsp_head;
    logic              rsp_avail, rsp_last;
    step_e             kind;

    hsl_line_watch i_watch (
        .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n),
        .prev_tip_n(prev_tip_n), .prev_ack_n(prev_ack_n),
        .lines_changed(lines_changed), .ack_changed(ack_changed)
    );

    hsl_capture_buf #(.DEPTH(CAP_DEPTH), .W(DATA_W)) i_cap (
        .clk(clk), .rst_n(rst_n),
        .push(kind == ST_CAPTURE), .din(sr_q), .clear(kind == ST_END),
        .count(cap_count), .full(cap_full),
        .rd_addr(cap_rd_addr), .rd_data(cap_rd_data)
    );

    hsl_response_buf #(.DEPTH(RSP_DEPTH), .W(DATA_W)) i_rsp (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rsp_wr), .wr_addr(rsp_wr_addr), .wr_data(rsp_wr_data),
        .load(rsp_load), .load_len(rsp_len), .pop(kind == ST_RESPOND),
        .head(rsp_head), .avail(rsp_avail), .last(rsp_last)
    );

    // Classify this cycle's handshake situation into one event.
    always_comb begin
        kind = ST_NONE;
        if (!tip_n) begin
            if (dir_h2d) begin
                if (lines_changed && !cap_full) kind = ST_CAPTURE;
            end else if (lines_changed && rsp_avail) begin
                kind = ST_RESPOND;
            end
        end else if (prev_tip_n && ack_changed) begin
            kind = ST_SYNC;
        end else if (!prev_tip_n) begin
            kind = ST_END;
        end else begin
            kind = ST_IDLE;
        end
    end

    // Shift register: response byte on a step, else host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (kind == ST_RESPOND) begin
            sr_q <= rsp_head;
        end else if (sr_wr) begin
            sr_q <= sr_wdata;
        end
    end

    // Interrupt flag: any step or load sets it, host read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_flag <= 1'b0;
        end else if (kind inside {ST_CAPTURE, ST_RESPOND, ST_SYNC, ST_END} || rsp_load) begin
            sr_flag <= 1'b1;
        end else if (sr_rd) begin
            sr_flag <= 1'b0;
        end
    end

    // Request line: released after last byte, mirrors ack in sync, low when data waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_n <= 1'b1;
        end else if (kind == ST_RESPOND && rsp_last) begin
            req_n <= 1'b1;
        end else if (kind == ST_SYNC) begin
            req_n <= ack_n;
        end else if ((kind == ST_END || kind == ST_IDLE) && rsp_avail) begin
            req_n <= 1'b0;
        end
    end

    // Packet hand-off pulse and length at the end of a non-empty capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_ready <= 1'b0;
            pkt_len   <= '0;
        end else begin
            pkt_ready <= (kind == ST_END) && (cap_count != '0);
            if (kind == ST_END && cap_count != '0) pkt_len <= cap_count;
        end
    end

endmodule

// File: rtl/hsl_byte_link_chk.sv
// Assertion checker for hsl_byte_link, attached by bind.
// Assumes: connected to the top's internal event and state signals.
module hsl_byte_link_chk #(
    parameter int CAP_DEPTH = 16,
    parameter int CNT_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tip_n,
    input logic             ack_n,
    input logic             prev_tip_n,
    input hsl_pkg::step_e   kind,
    input logic             rsp_last,
    input logic [CNT_W-1:0] cap_count,
    input logic             sr_flag,
    input logic             req_n,
    input logic             pkt_ready,
    input logic [CNT_W-1:0] pkt_len
);
    import hsl_pkg::*;

    // R2: a capture step sets the flag
    p_flag_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ST_CAPTURE) |=> sr_flag);

    // R3: the capture count never exceeds the buffer depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_count <= CNT_W'(CAP_DEPTH));

    // R4: a packet pulse carries a non-zero length
    p_pkt_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> (pkt_len != '0));

    // R4: a packet pulse follows a release of in-progress
    p_pkt_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |-> ($past(tip_n) && !$past(prev_tip_n)));

    // R4: the packet pulse lasts one cycle
    p_pkt_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ready |=> !pkt_ready);

    // R5: request released after the last response byte
    p_req_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ST_RESPOND && rsp_last) |=> req_n);

    // R6: idle sync mirrors acknowledge onto request
    p_sync_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ST_SYNC) |=> (req_n == $past(ack_n)));

endmodule

bind hsl_byte_link hsl_byte_link_chk #(.CAP_DEPTH(CAP_DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n),
    .prev_tip_n(prev_tip_n), .kind(kind), .rsp_last(rsp_last),
    .cap_count(cap_count), .sr_flag(sr_flag), .req_n(req_n),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len)
);

// File: tb/test_hsl_byte_link.sv
`timescale 1ns/1ps
module test_hsl_byte_link;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tip_n = 1'b1, ack_n = 1'b1, dir_h2d = 1'b1;
    logic       sr_wr = 1'b0, sr_rd = 1'b0;
    logic [7:0] sr_wdata = '0;
    logic [7:0] sr_q;
    logic       sr_flag, req_n, pkt_ready;
    logic [4:0] pkt_len;
    logic [3:0] cap_rd_addr = '0;
    logic [7:0] cap_rd_data;
    logic       rsp_wr = 1'b0, rsp_load = 1'b0;
    logic [6:0] rsp_wr_addr = '0;
    logic [7:0] rsp_wr_data = '0;
    logic [7:0] rsp_len = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hsl_byte_link i_hsl_byte_link (
        .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n), .dir_h2d(dir_h2d),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_rd(sr_rd), .sr_q(sr_q),
        .sr_flag(sr_flag), .req_n(req_n), .pkt_ready(pkt_ready), .pkt_len(pkt_len),
        .cap_rd_addr(cap_rd_addr), .cap_rd_data(cap_rd_data),
        .rsp_wr(rsp_wr), .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data),
        .rsp_load(rsp_load), .rsp_len(rsp_len)
    );

    // Row: {tip_n, ack_n, sr byte, expected flag, expected packet pulse}
    localparam logic [11:0] H2D_TAB [0:4] = '{
        {1'b0, 1'b1, 8'hA1, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'hB2, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'hC3, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'hD4, 1'b1, 1'b0},
        {1'b1, 1'b1, 8'h00, 1'b1, 1'b1}
    };

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Write sr and clear the flag on steady lines, then change the lines.
    task automatic step(input logic t, input logic a, input logic wr,
                        input logic [7:0] d, input logic rd_same);
        @(negedge clk);
        sr_wr = wr; sr_wdata = d; sr_rd = 1'b1;
        @(negedge clk);
        sr_wr = 1'b0; sr_rd = rd_same; tip_n = t; ack_n = a;
        @(negedge clk);
        sr_rd = 1'b0;
    endtask

    task automatic load_rsp(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rsp_wr = 1'b1; rsp_wr_addr = 7'(i); rsp_wr_data = 8'((i * 3 + seed) & 8'hFF);
        end
        @(negedge clk);
        rsp_wr = 1'b0; rsp_load = 1'b1; rsp_len = 8'(n);
        @(negedge clk);
        rsp_load = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req_n", req_n, 1);
        check("R1 sr_flag", sr_flag, 0);
        check("R1 pkt_ready", pkt_ready, 0);
        check("R1 pkt_len", pkt_len, 0);
        check("R1 sr_q", sr_q, 0);

        // R2/R10/R4: host-to-device vector table
        dir_h2d = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step(H2D_TAB[i][11], H2D_TAB[i][10], 1'b1, H2D_TAB[i][9:2], 1'b0);
            check(i == 2 ? "R10 steady flag" : "R2 step flag", sr_flag, H2D_TAB[i][1]);
            check("R4 pkt_ready", pkt_ready, H2D_TAB[i][0]);
        end
        check("R4 pkt_len", pkt_len, 3);
        cap_rd_addr = 4'd0; #1 check("R2 slot0", cap_rd_data, 8'hA1);
        cap_rd_addr = 4'd1; #1 check("R2 slot1", cap_rd_data, 8'hB2);
        cap_rd_addr = 4'd2; #1 check("R10 slot2", cap_rd_data, 8'hD4);

        // R3: overflow beyond 16 bytes
        step(1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
        for (int i = 1; i < 20; i++) begin
            step(1'b0, ~ack_n, 1'b1, 8'(i), 1'b0);
            if (i == 16) check("R3 dropped no flag", sr_flag, 0);
        end
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R3 pkt_ready", pkt_ready, 1);
        check("R3 pkt_len", pkt_len, 16);
        cap_rd_addr = 4'd15; #1 check("R3 slot15", cap_rd_data, 15);
        cap_rd_addr = 4'd0;  #1 check("R3 slot0", cap_rd_data, 0);

        // R9: set wins over clear, then clear alone
        step(1'b0, 1'b1, 1'b1, 8'h5A, 1'b1);
        check("R9 set wins", sr_flag, 1);
        sr_rd = 1'b1; @(negedge clk); sr_rd = 1'b0;
        check("R9 clear", sr_flag, 0);
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R4 count reset len", pkt_len, 1);
        cap_rd_addr = 4'd0; #1 check("R4 new slot0", cap_rd_data, 8'h5A);

        // R6: idle sync mirrors ack
        step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R6 req low", req_n, 0);
        check("R6 flag", sr_flag, 1);
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R6 req high", req_n, 1);

        // R8/R7: 3-byte response {01,04,07}
        sr_rd = 1'b1; @(negedge clk); sr_rd = 1'b0;
        load_rsp(3, 1);
        check("R8 load flag", sr_flag, 1);
        @(negedge clk);
        check("R7 data waiting", req_n, 0);

        // R5: device-to-host delivery
        dir_h2d = 1'b0;
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R5 byte0", sr_q, 8'h01);
        check("R5 flag", sr_flag, 1);
        check("R5 req still low", req_n, 0);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R5 byte1", sr_q, 8'h04);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R5 byte2", sr_q, 8'h07);
        check("R5 req released", req_n, 1);
        step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R5 exhausted sr", sr_q, 8'h07);
        check("R5 exhausted flag", sr_flag, 0);
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R4 end flag", sr_flag, 1);
        check("R4 empty no pkt", pkt_ready, 0);
        check("R7 none waiting", req_n, 1);

        // R8: reload restarts index after partial read
        load_rsp(3, 16);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R8 first of three", sr_q, 16);
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R7 after end", req_n, 0);
        load_rsp(2, 8'h40);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R8 index reset", sr_q, 8'h40);
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);

        // R8/R5: full 128-byte response
        load_rsp(128, 2);
        check("R8 load 128 flag", sr_flag, 1);
        step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R5 128 byte0", sr_q, 2);
        for (int i = 1; i < 128; i++) step(1'b0, ~ack_n, 1'b0, 8'h00, 1'b0);
        check("R5 128 last", sr_q, (127 * 3 + 2) & 8'hFF);
        check("R5 128 flag", sr_flag, 1);
        check("R5 128 req", req_n, 1);
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule